// File: doc/BRIEF.md
# Edge-Triggered Interrupt Request Front End

This block sits between a small 8-bit CPU core's interrupt pins and its opcode fetch stage. It takes an asynchronous non-maskable request line, a set of level-sensitive maskable request lines and an overflow-set line, and passes each through a synchronizer. At every opcode-fetch boundary it decides whether the opcode coming from memory goes through unchanged, or whether a fixed entry opcode (0x00) is substituted so that the core runs its interrupt entry sequence.

The non-maskable request is remembered as an event. A deasserted-to-asserted transition sets a pending latch. That latch holds until the entry sequencer reports that the non-maskable vector has been read, even if the line is still high. The maskable requests are sampled as levels and gated by the processor's interrupt-mask bit. An inhibit input holds off every kind of entry. A wake output releases a wait-for-interrupt halt. A one-cycle pulse tells the status register to set its overflow flag on each rising edge of the overflow-set line.

Top module: `intr_arbiter`

## Requirements
- R1: `nmi_pending` rises on the third rising clock edge after `nmi_in` goes from 0 to 1, through a two-stage synchronizer and an edge detector. Holding `nmi_in` high never sets it again once it has been cleared; only a new 0-to-1 transition does.
- R2: Once set, `nmi_pending` stays 1 until a cycle with `nmi_vec_done` = 1. It is 0 after that edge even when `nmi_in` is still 1. A new edge arriving in the same cycle wins over the clear.
- R3: The synchronized bits of `irq_in` are ORed as level-sensitive maskable requests. `i_mask` = 1 blocks them and never blocks a pending non-maskable request.
- R4: In a cycle with `fetch_go` = 1 and `inhibit` = 0, if `nmi_pending` = 1 or an unmasked maskable request is active, then `force_entry` = 1 and `opc_out` = 0x00. Otherwise `opc_out` equals `opc_in`. `force_entry` is 0 whenever `fetch_go` = 0.
- R5: While `inhibit` = 1, `force_entry` is 0 and `opc_out` equals `opc_in`. A pending non-maskable request stays pending.
- R6: While `rst_n` = 0, the synchronizers, the line-state registers, `nmi_pending`, `taken` and `v_set_pulse` are all 0.
- R7: `wake` is 1 exactly when `nmi_pending` = 1 or synchronized `irq_in[0]` (the primary request) = 1. The mask does not gate it, and `irq_in[1]` alone does not raise it.
- R8: Each 0-to-1 transition of `ovf_set_in` produces exactly one cycle of `v_set_pulse` = 1. Holding the line high produces no further pulse.
- R9: `taken` becomes 1 on the clock edge that ends a cycle with `force_entry` = 1. It returns to 0 on the edge that ends a cycle with `entry_done` = 1, unless a new entry is forced in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| nmi_in | input | 1 | Asynchronous non-maskable request, active high |
| irq_in | input | N_IRQ | Asynchronous maskable requests, active high; bit 0 is the primary |
| ovf_set_in | input | 1 | Asynchronous overflow-set line, active high |
| i_mask | input | 1 | Processor interrupt-mask bit |
| inhibit | input | 1 | Holds off every interrupt entry |
| fetch_go | input | 1 | Opcode-fetch boundary strobe |
| opc_in | input | OPC_W | Opcode read from memory |
| nmi_vec_done | input | 1 | Sequencer has read the non-maskable vector |
| entry_done | input | 1 | Sequencer has finished the entry sequence |
| opc_out | output | OPC_W | Opcode handed to decode |
| force_entry | output | 1 | Entry opcode substituted this cycle |
| taken | output | 1 | An interrupt entry is in progress |
| nmi_pending | output | 1 | Latched non-maskable event |
| wake | output | 1 | Release for the wait-for-interrupt halt |
| v_set_pulse | output | 1 | One-cycle request to set the overflow flag |

## Verification
The bench holds the non-maskable line high across the vector-done clear. A level-sampling design would re-raise the pending flag and take the same event twice. It asserts the mask bit while a non-maskable event is pending, which catches a design that lets the mask gate it. It raises inhibit with an event pending and checks both that nothing is forced and that the event survives; a wrong design would drop the event or take it anyway. It also counts overflow pulses while the line is held high, and checks that the secondary request alone leaves the wake output low.

// File: rtl/intr_pkg.sv
package intr_pkg;
   // Index of each source inside the synchronizer bundle.
   localparam int SRC_NMI = 0;
   localparam int SRC_OVF = 1;
   localparam int SRC_IRQ0 = 2;

   typedef enum logic [1:0] {
      FETCH_PASS  = 2'd0,
      FETCH_NMI   = 2'd1,
      FETCH_IRQ   = 2'd2
   } fetch_pick_e;
endpackage

// File: rtl/intr_sync.sv
module intr_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/intr_rise_det.sv
module intr_rise_det #(
   parameter int WIDTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] rise
);
   logic [WIDTH-1:0] lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl;
   end

   assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/intr_flag.sv
module intr_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   // Set has priority so that a fresh event is never lost to a clear.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter #(
   parameter int               N_IRQ       = 2,
   parameter int               SYNC_STAGES = 2,
   parameter int               OPC_W       = 8,
   parameter logic [OPC_W-1:0] ENTRY_OPC   = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             nmi_in,
   input  logic [N_IRQ-1:0] irq_in,
   input  logic             ovf_set_in,
   input  logic             i_mask,
   input  logic             inhibit,
   input  logic             fetch_go,
   input  logic [OPC_W-1:0] opc_in,
   input  logic             nmi_vec_done,
   input  logic             entry_done,
   output logic [OPC_W-1:0] opc_out,
   output logic             force_entry,
   output logic             taken,
   output logic             nmi_pending,
   output logic             wake,
   output logic             v_set_pulse
);
   import intr_pkg::*;

   localparam int BUNDLE_W = N_IRQ + 2;

   generate
      if (N_IRQ < 1) begin : g_bad_irq
         $error("N_IRQ must be at least 1");
      end
      if (SYNC_STAGES == 1) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 (bypass) or at least 2");
      end
      if (OPC_W < 1) begin : g_bad_opc
         $error("OPC_W must be positive");
      end
   endgenerate

   logic [BUNDLE_W-1:0] raw_b, sync_b;
   logic [1:0]          edge_b;
   logic [N_IRQ-1:0]    irq_s;
   logic                irq_live;
   fetch_pick_e         pick;

   assign raw_b = {irq_in, ovf_set_in, nmi_in};

   intr_sync #(.WIDTH(BUNDLE_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_b),
      .q    (sync_b)
   );

   intr_rise_det #(.WIDTH(2)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  ({sync_b[SRC_OVF], sync_b[SRC_NMI]}),
      .rise (edge_b)
   );

   assign irq_s    = sync_b[BUNDLE_W-1:SRC_IRQ0];
   assign irq_live = (|irq_s) & ~i_mask;

   intr_flag u_nmi_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (edge_b[0]),
      .clr  (nmi_vec_done),
      .q    (nmi_pending)
   );

   always_comb begin
      pick = FETCH_PASS;
      if (fetch_go && !inhibit) begin
         if (nmi_pending)   pick = FETCH_NMI;
         else if (irq_live) pick = FETCH_IRQ;
      end
   end

   assign force_entry = (pick != FETCH_PASS);
   assign opc_out     = force_entry ? ENTRY_OPC : opc_in;

   intr_flag u_taken_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (force_entry),
      .clr  (entry_done),
      .q    (taken)
   );

   assign wake = nmi_pending | irq_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_set_pulse <= 1'b0;
      else        v_set_pulse <= edge_b[1];
   end
endmodule

// File: rtl/intr_arbiter_chk.sv
module intr_arbiter_chk #(
   parameter int N_IRQ = 2,
   parameter int OPC_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_IRQ-1:0] irq_in,
   input logic             i_mask,
   input logic             inhibit,
   input logic             fetch_go,
   input logic [OPC_W-1:0] opc_in,
   input logic             nmi_vec_done,
   input logic             entry_done,
   input logic [OPC_W-1:0] opc_out,
   input logic             force_entry,
   input logic             taken,
   input logic             nmi_pending,
   input logic             wake,
   input logic             v_set_pulse
);
   assert_nmi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_pending && !nmi_vec_done |=> nmi_pending);

   assert_mask_no_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_go && !inhibit && nmi_pending && i_mask |-> force_entry);

   assert_idle_no_force_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_go |-> !force_entry && opc_out == opc_in);

   assert_inhibit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit |-> !force_entry && opc_out == opc_in);

   assert_wake_nmi_R7: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_pending |-> wake);

   assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      v_set_pulse |=> !v_set_pulse);

   assert_taken_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      force_entry |=> taken);

   assert_taken_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      taken && !entry_done |=> taken);
endmodule

bind intr_arbiter intr_arbiter_chk #(.N_IRQ(N_IRQ), .OPC_W(OPC_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .irq_in      (irq_in),
   .i_mask      (i_mask),
   .inhibit     (inhibit),
   .fetch_go    (fetch_go),
   .opc_in      (opc_in),
   .nmi_vec_done(nmi_vec_done),
   .entry_done  (entry_done),
   .opc_out     (opc_out),
   .force_entry (force_entry),
   .taken       (taken),
   .nmi_pending (nmi_pending),
   .wake        (wake),
   .v_set_pulse (v_set_pulse)
);

// File: tb/intr_arbiter_tb.sv
`timescale 1ns/1ps
module intr_arbiter_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       nmi_in = 1'b0;
   logic [1:0] irq_in = 2'b00;
   logic       ovf_set_in = 1'b0;
   logic       i_mask = 1'b0;
   logic       inhibit = 1'b0;
   logic       fetch_go = 1'b0;
   logic [7:0] opc_in = 8'h00;
   logic       nmi_vec_done = 1'b0;
   logic       entry_done = 1'b0;
   logic [7:0] opc_out;
   logic       force_entry, taken, nmi_pending, wake, v_set_pulse;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   intr_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .irq_in(irq_in),
      .ovf_set_in(ovf_set_in), .i_mask(i_mask), .inhibit(inhibit),
      .fetch_go(fetch_go), .opc_in(opc_in), .nmi_vec_done(nmi_vec_done),
      .entry_done(entry_done), .opc_out(opc_out), .force_entry(force_entry),
      .taken(taken), .nmi_pending(nmi_pending), .wake(wake),
      .v_set_pulse(v_set_pulse)
   );

   always @(posedge clk) if (v_set_pulse) pulses++;

   // {irq[1:0], i_mask, inhibit, opc_in, exp_force, exp_opc}
   localparam logic [20:0] VEC [8] = '{
      {2'b00, 1'b0, 1'b0, 8'hA9, 1'b0, 8'hA9},
      {2'b01, 1'b0, 1'b0, 8'h4C, 1'b1, 8'h00},
      {2'b10, 1'b0, 1'b0, 8'hEA, 1'b1, 8'h00},
      {2'b11, 1'b1, 1'b0, 8'h20, 1'b0, 8'h20},
      {2'b01, 1'b1, 1'b0, 8'h60, 1'b0, 8'h60},
      {2'b10, 1'b0, 1'b1, 8'h85, 1'b0, 8'h85},
      {2'b11, 1'b0, 1'b0, 8'hFF, 1'b1, 8'h00},
      {2'b00, 1'b1, 1'b1, 8'h00, 1'b0, 8'h00}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse_vec_done();
      @(negedge clk) nmi_vec_done = 1'b1;
      @(negedge clk) nmi_vec_done = 1'b0;
   endtask

   task automatic pulse_entry_done();
      @(negedge clk) entry_done = 1'b1;
      @(negedge clk) entry_done = 1'b0;
   endtask

   initial begin
      repeat (30000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R6: reset state
      repeat (3) @(negedge clk);
      chk("R6 pending", {7'd0, nmi_pending}, 8'd0);
      chk("R6 taken", {7'd0, taken}, 8'd0);
      chk("R6 vpulse", {7'd0, v_set_pulse}, 8'd0);
      chk("R6 wake", {7'd0, wake}, 8'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 R3 R5 R9: table of fetch decisions with maskable sources
      for (int k = 0; k < 8; k++) begin
         irq_in = VEC[k][20:19];
         i_mask = VEC[k][18];
         inhibit = VEC[k][17];
         opc_in = VEC[k][16:9];
         settle();
         fetch_go = 1'b1;
         #1;
         chk($sformatf("R4 force vec%0d", k), {7'd0, force_entry}, {7'd0, VEC[k][8]});
         chk($sformatf("R4 opc vec%0d", k), opc_out, VEC[k][7:0]);
         @(negedge clk) fetch_go = 1'b0;
         chk($sformatf("R9 taken vec%0d", k), {7'd0, taken}, {7'd0, VEC[k][8]});
         pulse_entry_done();
         chk($sformatf("R9 clear vec%0d", k), {7'd0, taken}, 8'd0);
      end
      irq_in = 2'b00; i_mask = 1'b0; inhibit = 1'b0;
      settle();

      // R7: secondary alone no wake, primary under mask wakes
      irq_in = 2'b10; settle();
      chk("R7 secondary", {7'd0, wake}, 8'd0);
      irq_in = 2'b01; i_mask = 1'b1; settle();
      chk("R7 primary masked", {7'd0, wake}, 8'd1);
      irq_in = 2'b00; settle();

      // R1: edge latency, pending on third edge
      @(negedge clk) nmi_in = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R1 early", {7'd0, nmi_pending}, 8'd0);
      @(negedge clk);
      chk("R1 set", {7'd0, nmi_pending}, 8'd1);
      chk("R7 nmi wake", {7'd0, wake}, 8'd1);

      // R4: no fetch strobe, no forcing
      opc_in = 8'h5A; #1;
      chk("R4 idle", {7'd0, force_entry}, 8'd0);

      // R5: inhibit blocks pending event, keeps it
      inhibit = 1'b1; fetch_go = 1'b1; #1;
      chk("R5 force", {7'd0, force_entry}, 8'd0);
      chk("R5 opc", opc_out, 8'h5A);
      @(negedge clk) fetch_go = 1'b0; inhibit = 1'b0;
      chk("R5 kept", {7'd0, nmi_pending}, 8'd1);

      // R3: mask does not block the event
      fetch_go = 1'b1; #1;
      chk("R3 nmi masked", {7'd0, force_entry}, 8'd1);
      chk("R3 opc", opc_out, 8'h00);
      @(negedge clk) fetch_go = 1'b0; i_mask = 1'b0;
      pulse_entry_done();

      // R2: cleared by vector done while line still high
      repeat (5) @(negedge clk);
      chk("R2 held", {7'd0, nmi_pending}, 8'd1);
      pulse_vec_done();
      chk("R2 cleared", {7'd0, nmi_pending}, 8'd0);
      repeat (10) @(negedge clk);
      chk("R1 no retrigger", {7'd0, nmi_pending}, 8'd0);
      nmi_in = 1'b0; settle();
      nmi_in = 1'b1; settle();
      chk("R1 new edge", {7'd0, nmi_pending}, 8'd1);

      // R6: reset in mid-run clears the event
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk);
      chk("R6 midrun", {7'd0, nmi_pending}, 8'd0);
      rst_n = 1'b1; nmi_in = 1'b0; settle();

      // R8: one pulse per rise
      pulses = 0;
      ovf_set_in = 1'b1;
      repeat (12) @(negedge clk);
      chk("R8 one pulse", pulses[7:0], 8'd1);
      ovf_set_in = 1'b0; settle();
      ovf_set_in = 1'b1; settle();
      chk("R8 second rise", pulses[7:0], 8'd2);
      ovf_set_in = 1'b0; settle();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule